// File: doc/BRIEF.md
# Small-Opcode Arithmetic Unit

This block is a purely combinational 32-bit arithmetic unit. It takes two unsigned operands and a 3-bit function code, and returns one 32-bit result. It offers addition, increment, subtraction, decrement and multiplication. The result follows any change on an input without a clock. There are no carry or status outputs.

A single add/subtract pair is shared by all four additive operations. Its second operand is picked by function bit 0: the B operand when that bit is 0, and the constant one when it is 1. Function bits 2:1 drive a result selector with four choices:

- 00 selects the sum.
- 01 selects the difference.
- 10 selects the product from a separate multiplier.
- 11 selects the unused group, which drives all zeros.

The block is stateless, so it has no states or transitions. The selector's four choices are its only modes.

Top module: `arith_unit`

## Requirements
- R1: With func = 3'b000, result equals op_a + op_b modulo 2^32.
- R2: With func = 3'b001, result equals op_a + 1 modulo 2^32, and op_b has no effect.
- R3: With func = 3'b010, result equals op_a - op_b modulo 2^32.
- R4: With func = 3'b011, result equals op_a - 1 modulo 2^32, and op_b has no effect.
- R5: With func = 3'b100 or 3'b101, result equals the low 32 bits of the unsigned product op_a * op_b; func bit 0 has no effect.
- R6: With func = 3'b110 or 3'b111, result is all zeros for any operands.
- R7: The block holds no state: result reflects the current inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand, unsigned |
| op_b | input | 32 | Second operand, unsigned |
| func | input | 3 | Function code: bits 2:1 pick the group, bit 0 picks B or one |
| result | output | 32 | Low 32 bits of the selected operation |

## Verification
The checker watches every input change and checks each additive code by its inverse relation. A sum minus B must give back A, and a difference plus one must give back A. It also checks that the unused group is zero, and that multiplying by zero or by one gives zero or the operand. The exact product value for general operands is left to the bench. So are the corner operands (zero, one, all ones, the most negative pattern) and the wrap-around they cause. The bench also shows two things a single-instant check cannot: that bit 0 is ignored for multiplication, and that the result moves without a clock edge.

// File: rtl/arith_pkg.sv
package arith_pkg;
    localparam int FUNC_W = 3;

    // Group select taken from function bits 2:1
    typedef enum logic [1:0] {
        GRP_ADD  = 2'b00,
        GRP_SUB  = 2'b01,
        GRP_MUL  = 2'b10,
        GRP_NONE = 2'b11
    } grp_e;
endpackage

// File: rtl/addend_mux.sv
module addend_mux #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_b,
    input  logic             use_one,
    output logic [WIDTH-1:0] addend
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        if (use_one) addend = ONE;
        else         addend = op_b;
    end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] addend,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] diff
);
    // Both wrap modulo 2^WIDTH
    always_comb begin
        sum  = op_a + addend;
        diff = op_a - addend;
    end
endmodule

// File: rtl/mul_core.sv
module mul_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] prod
);
    localparam int FULL_W = 2 * WIDTH;

    logic [FULL_W-1:0] prod_full;

    // Unsigned product, kept to the low half
    always_comb begin
        prod_full = {{WIDTH{1'b0}}, op_a} * {{WIDTH{1'b0}}, op_b};
        prod      = prod_full[WIDTH-1:0];
    end
endmodule

// File: rtl/arith_unit.sv
module arith_unit
    import arith_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic [FUNC_W-1:0] func,
    output logic [WIDTH-1:0]  result
);
    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] diff;
    logic [WIDTH-1:0] prod;
    grp_e             grp;

    assign grp = grp_e'(func[2:1]);

    addend_mux #(.WIDTH(WIDTH)) u_addend (
        .op_b    (op_b),
        .use_one (func[0]),
        .addend  (addend)
    );

    addsub_core #(.WIDTH(WIDTH)) u_addsub (
        .op_a   (op_a),
        .addend (addend),
        .sum    (sum),
        .diff   (diff)
    );

    mul_core #(.WIDTH(WIDTH)) u_mul (
        .op_a (op_a),
        .op_b (op_b),
        .prod (prod)
    );

    // Output selector: every branch drives result
    always_comb begin
        unique case (grp)
            GRP_ADD:  result = sum;
            GRP_SUB:  result = diff;
            GRP_MUL:  result = prod;
            GRP_NONE: result = '0;
            default:  result = '0;
        endcase
    end
endmodule

// File: rtl/arith_unit_chk.sv
module arith_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [2:0]       func,
    input logic [WIDTH-1:0] result
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        if (func == 3'b000) begin
            AST_ADD_INVERSE: assert (result - op_b == op_a);  // R1
        end
        if (func == 3'b001) begin
            AST_INC_INVERSE: assert (result - ONE == op_a);   // R2
        end
        if (func == 3'b010) begin
            AST_SUB_INVERSE: assert (result + op_b == op_a);  // R3
        end
        if (func == 3'b011) begin
            AST_DEC_INVERSE: assert (result + ONE == op_a);   // R4
        end
        if (func[2:1] == 2'b10 && op_b == '0) begin
            AST_MUL_BY_ZERO: assert (result == '0);           // R5
        end
        if (func[2:1] == 2'b10 && op_b == ONE) begin
            AST_MUL_BY_ONE: assert (result == op_a);          // R5
        end
        if (func[2:1] == 2'b11) begin
            AST_UNUSED_ZERO: assert (result == '0);           // R6
        end
    end
endmodule

bind arith_unit arith_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a   (op_a),
    .op_b   (op_b),
    .func   (func),
    .result (result)
);

// File: tb/arith_unit_tb.sv
module arith_unit_tb;
    logic        clk = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  func = 3'b110;
    logic [31:0] result;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;  // 125 MHz

    arith_unit u_dut (
        .op_a   (op_a),
        .op_b   (op_b),
        .func   (func),
        .result (result)
    );

    function automatic logic [31:0] model(input logic [2:0] f,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
        logic [63:0] p;
        p = {32'd0, a} * {32'd0, b};
        case (f)
            3'b000:         return a + b;
            3'b001:         return a + 32'd1;
            3'b010:         return a - b;
            3'b011:         return a - 32'd1;
            3'b100, 3'b101: return p[31:0];
            default:        return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] f);
        case (f)
            3'b000:         return "R1";
            3'b001:         return "R2";
            3'b010:         return "R3";
            3'b011:         return "R4";
            3'b100, 3'b101: return "R5";
            default:        return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies a vector and queues its expected result
    task automatic drive(input logic [2:0] f, input logic [31:0] a,
                         input logic [31:0] b);
        @(posedge clk);
        func = f;
        op_a = a;
        op_b = b;
        exp_q.push_back(model(f, a, b));
        tag_q.push_back(tag_of(f));
    endtask

    // Monitor: compares at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, result, e);
        end
    end

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        logic [31:0] corners[6];
        corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                    32'h7FFF_FFFF, 32'h1234_5678};

        // Unused code at start: zero output (R6)
        #1;
        check("R6", result, 32'h0);

        // R7: no clock edge between input change and sample
        func = 3'b000; op_a = 32'd5; op_b = 32'd7;
        #1;
        check("R7", result, 32'd12);
        op_b = 32'd8;
        #1;
        check("R7", result, 32'd13);
        func = 3'b011;
        #1;
        check("R7", result, 32'd4);

        // All codes over all corner pairs (R1..R6)
        for (int f = 0; f < 8; f++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    drive(3'(f), corners[i], corners[j]);
                end
            end
        end

        // R2 and R4: B ignored, wrap at the ends
        drive(3'b001, 32'hFFFF_FFFF, 32'hDEAD_BEEF);
        drive(3'b011, 32'h0, 32'hDEAD_BEEF);
        // R5: bit 0 ignored for multiply
        drive(3'b100, 32'h0001_0003, 32'h0002_0005);
        drive(3'b101, 32'h0001_0003, 32'h0002_0005);

        repeat (3) @(posedge clk);
        done = 1'b1;
        finish_run();
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
            finish_run();
        end
    end
endmodule